// File: doc/BRIEF.md
# Preset-Truncated Cascadable Modulus Counter

This block is a synchronous binary counter built from a chain of equal-width stages. The chain counts upward and, when every stage holds all-ones together, it reloads a fixed preset value rather than wrapping to zero. With a preset of (2^W − M), the chain runs from the preset up to the all-ones value and back, so it has exactly M states per cycle. For example, a single 4-bit stage preset to 4 gives modulus 12, and four 4-bit stages preset to 0x63C0 give modulus 40,000.

Counting is gated by two enables, `cnt_en_p` and `cnt_en_t`. Inside the chain, each stage passes a gated terminal-count carry to the enable of the stage above it. The carry out of the top stage is the block's `carry_out`, and it can drive the enable of another instance further down the line. A synchronous parallel load can place any value in the chain. Reset puts every stage at its slice of the preset.

Top module: `trunc_mod_counter`

## Requirements
- R1: While reset is held and after it is released, `count` equals the parameter PRESET and `carry_out` is low. PRESET defaults to 0x63C0 in a 16-bit chain of four 4-bit stages.
- R2: When `cnt_en_p` and `cnt_en_t` are both high, `load` is low and `count` is not all-ones, `count` rises by exactly one on each clock.
- R3: When either enable is low and `load` is low, `count` holds its value.
- R4: `carry_out` is high exactly when `count` is all-ones and `cnt_en_t` is high. It does not depend on `cnt_en_p`.
- R5: When `count` is all-ones, both enables are high and `load` is low, the next `count` is PRESET and not zero.
- R6: When `count` is all-ones and `cnt_en_p` is low, no reload happens and `count` stays all-ones.
- R7: When `load` is high, `count` takes `load_val` on the next clock. This happens whatever the enables are, and `load` wins over both reload and counting.
- R8: With both enables held high, exactly 2^W − PRESET clocks pass between successive `carry_out` pulses. That is 40,000 clocks for the default chain and 12 clocks for one 4-bit stage preset to 4.
- R9: A stage above the lowest one advances only on a clock where every stage below it is all-ones. For example, 0x00FF steps to 0x0100, and 0x0FFF steps to 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en_p | input | 1 | Count enable that does not gate the carry |
| cnt_en_t | input | 1 | Count enable that also gates the carry |
| load | input | 1 | Synchronous parallel load |
| load_val | input | STAGE_W*NUM_STAGES | Value taken by `load` |
| count | output | STAGE_W*NUM_STAGES | Current chain value |
| carry_out | output | 1 | Chain terminal-count carry, gated by `cnt_en_t` |

## Verification
The embedded assertions check on every clock the local step rules: the one-step increment, the hold while disabled, the load capture, the reload to the preset, and the carry being equal to the gated all-ones condition of the whole chain. Only the bench's scenarios can show the properties that span many cycles or several stages. These are the exact number of clocks between carries for both the 40,000 and the 12 configurations, the wrap of the low stages into the upper ones at stage boundaries, and load winning over a pending reload.

// File: rtl/tmc_pkg.sv
`timescale 1ns/1ps
package tmc_pkg;
  // Source chosen for a stage's next value, in priority order.
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_STEP   = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_LOAD   = 2'd3
  } tmc_sel_e;
endpackage

// File: rtl/tmc_rst_sync.sv
`timescale 1ns/1ps
module tmc_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/tmc_stage.sv
`timescale 1ns/1ps
module tmc_stage
  import tmc_pkg::*;
#(
  parameter int          W      = 4,
  parameter logic [W-1:0] PRESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ep,
  input  logic         et,
  input  logic         load,
  input  logic [W-1:0] load_d,
  input  logic         reload,
  output logic [W-1:0] q,
  output logic         rco
);
  localparam logic [W-1:0] ONE = W'(1);

  tmc_sel_e     sel;
  logic [W-1:0] q_nxt;
  logic         adv;

  assign adv = ep & et;

  always_comb begin
    if (load)        sel = SEL_LOAD;
    else if (reload) sel = SEL_RELOAD;
    else if (adv)    sel = SEL_STEP;
    else             sel = SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      SEL_LOAD:   q_nxt = load_d;
      SEL_RELOAD: q_nxt = PRESET;
      SEL_STEP:   q_nxt = q + ONE;
      default:    q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= PRESET;
    else        q <= q_nxt;
  end

  // Terminal count, gated by the carry-side enable.
  assign rco = (&q) & et;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && adv && !load && !reload |=> q == $past(q) + ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !adv && !load |=> $stable(q));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && load |=> q == $past(load_d));
endmodule

// File: rtl/trunc_mod_counter.sv
`timescale 1ns/1ps
module trunc_mod_counter #(
  parameter int STAGE_W    = 4,
  parameter int NUM_STAGES = 4,
  parameter logic [STAGE_W*NUM_STAGES-1:0] PRESET = 16'h63C0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cnt_en_p,
  input  logic                          cnt_en_t,
  input  logic                          load,
  input  logic [STAGE_W*NUM_STAGES-1:0] load_val,
  output logic [STAGE_W*NUM_STAGES-1:0] count,
  output logic                          carry_out
);
  localparam int W = STAGE_W * NUM_STAGES;

  logic              rst_sync_n;
  logic [NUM_STAGES:0] et_chain;
  logic              reload;

  tmc_rst_sync #(.SYNC_STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign et_chain[0] = cnt_en_t;
  // Whole chain at all-ones with counting enabled: reload the preset.
  assign reload = cnt_en_p & et_chain[NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    tmc_stage #(
      .W      (STAGE_W),
      .PRESET (PRESET[g*STAGE_W +: STAGE_W])
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .ep     (cnt_en_p),
      .et     (et_chain[g]),
      .load   (load),
      .load_d (load_val[g*STAGE_W +: STAGE_W]),
      .reload (reload),
      .q      (count[g*STAGE_W +: STAGE_W]),
      .rco    (et_chain[g+1])
    );
  end

  assign carry_out = et_chain[NUM_STAGES];

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n && (&count) && cnt_en_p && cnt_en_t && !load |=> count == PRESET);

  assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n && (&count) && !cnt_en_p && !load |=> (&count));

  assert_carry_set_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (&count) && cnt_en_t |-> carry_out);

  assert_carry_only_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry_out |-> (&count) && cnt_en_t);

  always_comb begin
    if (!rst_sync_n) assert_rst_R1: assert (count == PRESET || !rst_n || $isunknown(count));
  end

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/tb_trunc_mod_counter.sv
`timescale 1ns/1ps
module tb_trunc_mod_counter;
  localparam logic [15:0] PRE16 = 16'h63C0;

  logic        clk;
  logic        rst_n;
  logic        en_p, en_t;
  logic        load16, load12;
  logic [15:0] lv16;
  logic [3:0]  lv12;
  logic [15:0] cnt16;
  logic [3:0]  cnt12;
  logic        co16, co12;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  trunc_mod_counter #(.STAGE_W(4), .NUM_STAGES(4), .PRESET(PRE16)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en_p(en_p), .cnt_en_t(en_t),
    .load(load16), .load_val(lv16), .count(cnt16), .carry_out(co16));

  trunc_mod_counter #(.STAGE_W(4), .NUM_STAGES(1), .PRESET(4'd4)) dut_m12 (
    .clk(clk), .rst_n(rst_n), .cnt_en_p(en_p), .cnt_en_t(en_t),
    .load(load12), .load_val(lv12), .count(cnt12), .carry_out(co12));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load16(input logic [15:0] v);
    load16 = 1'b1; lv16 = v;
    step();
    load16 = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en_p = 0; en_t = 0; load16 = 0; load12 = 0; lv16 = '0; lv12 = '0;
    repeat (3) step();
    chk(cnt16 == PRE16, "R1 count in reset", cnt16, PRE16);
    rst_n = 1'b1;
    repeat (4) step();
    chk(cnt16 == PRE16, "R1 count after release", cnt16, PRE16);
    chk(co16 == 1'b0, "R1 carry after release", co16, 0);
    chk(cnt12 == 4'd4, "R1 m12 count after release", cnt12, 4);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    v = cnt16;
    en_p = 0; en_t = 0; repeat (3) step();
    chk(cnt16 == v, "R3 both enables low", cnt16, v);
    en_p = 1; en_t = 0; repeat (3) step();
    chk(cnt16 == v, "R3 en_t low", cnt16, v);
    en_p = 0; en_t = 1; repeat (3) step();
    chk(cnt16 == v, "R3 en_p low", cnt16, v);
  endtask

  task automatic t_step();
    logic [15:0] v;
    en_p = 0; en_t = 0;
    do_load16(16'h1230);
    v = 16'h1230;
    en_p = 1; en_t = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      v = v + 16'd1;
      chk(cnt16 == v, "R2 increment", cnt16, v);
    end
    en_p = 0; en_t = 0;
  endtask

  task automatic t_cascade();
    do_load16(16'h00FF);
    en_p = 1; en_t = 1; step(); en_p = 0; en_t = 0;
    chk(cnt16 == 16'h0100, "R9 wrap low byte", cnt16, 16'h0100);
    do_load16(16'h0FFF);
    en_p = 1; en_t = 1; step(); en_p = 0; en_t = 0;
    chk(cnt16 == 16'h1000, "R9 wrap three stages", cnt16, 16'h1000);
    do_load16(16'h00FE);
    en_p = 1; en_t = 1; step(); en_p = 0; en_t = 0;
    chk(cnt16 == 16'h00FF, "R9 no upper advance", cnt16, 16'h00FF);
  endtask

  task automatic t_carry();
    do_load16(16'hFFFF);
    en_p = 1; en_t = 0; #0.1;
    chk(co16 == 1'b0, "R4 carry gated by en_t", co16, 0);
    en_p = 0; en_t = 1; #0.1;
    chk(co16 == 1'b1, "R4 carry with en_p low", co16, 1);
    step();
    chk(cnt16 == 16'hFFFF, "R6 no reload with en_p low", cnt16, 16'hFFFF);
    en_p = 1; step(); en_p = 0; en_t = 0;
    chk(cnt16 == PRE16, "R5 reload to preset", cnt16, PRE16);
    do_load16(16'hFFFE);
    chk(co16 == 1'b0, "R4 no carry below all-ones", co16, 0);
  endtask

  task automatic t_load();
    en_p = 0; en_t = 0;
    do_load16(16'hA5A5);
    chk(cnt16 == 16'hA5A5, "R7 load while disabled", cnt16, 16'hA5A5);
    do_load16(16'hFFFF);
    en_p = 1; en_t = 1;
    do_load16(16'h1234);
    chk(cnt16 == 16'h1234, "R7 load beats reload", cnt16, 16'h1234);
    en_p = 0; en_t = 0;
  endtask

  task automatic t_period();
    int n;
    do_load16(16'hFFFF);
    en_p = 1; en_t = 1;
    for (int p = 0; p < 2; p++) begin
      n = 0;
      do begin
        step();
        n++;
      end while (!co16 && n < 70000);
      chk(n == 40000, "R8 chain period", n, 40000);
    end
    en_p = 0; en_t = 0;
  endtask

  task automatic t_m12();
    int n;
    load12 = 1'b1; lv12 = 4'hF; step(); load12 = 1'b0;
    en_p = 1; en_t = 1;
    step();
    chk(cnt12 == 4'd4, "R5 m12 15 to 4", cnt12, 4);
    n = 1;
    while (!co12 && n < 100) begin
      step();
      n++;
    end
    chk(n == 12, "R8 m12 period", n, 12);
    en_p = 0; en_t = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_hold();
    t_step();
    t_cascade();
    t_carry();
    t_load();
    t_m12();
    t_period();
    finish_run();
  end
endmodule